// File: doc/BRIEF.md
# Byte-Addressed Register Port over I2C

This block is an I2C target that lets an external bus controller read and write a 256-byte on-chip register array at standard-mode bus rates. It watches SCL and SDA with a much faster system clock. Both lines pass through a synchronizer and an agreement filter before any edge is taken from them. It recognises start and stop conditions and decodes a 7-bit device address. That address is a fixed type code plus three strap inputs, so up to eight copies can share one bus.

A write transfer starts with the address header. The first byte after it sets an internal byte pointer, and every later byte is stored at that pointer, which then steps forward. A read transfer returns bytes from the pointer, one per acknowledged byte, and stops when the controller answers with a NACK. To read from any chosen location, the controller sends a write header and a pointer byte, then a repeated start and a read header. SDA is never driven high: the block only produces an active-high pull-down enable for an open-drain pad.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start condition. It begins reception of a header byte from any state, including in the middle of a transfer (repeated start).
- R2: A rising SDA while SCL is high is a stop condition. It releases SDA and returns the block to idle, and the block drives nothing until the next start.
- R3: The header byte is received MSB first as a 7-bit address followed by a direction bit, where 1 selects read and 0 selects write. Bits are sampled on rising SCL.
- R4: The block responds only when address bits 6..3 equal 1010 and address bits 2..0 equal strap_i[2:0]. Otherwise it leaves SDA released for the whole transfer and stores nothing.
- R5: After a matched header and after every byte received in a write, the block pulls SDA low for the whole ninth SCL high phase.
- R6: In a write, the first byte after the header loads the pointer. Each later byte is stored at the pointer, and the pointer then increments, wrapping from 255 to 0.
- R7: In a read, the block sends the byte at the pointer MSB first, using SDA low for a 0 bit. The pointer increments after every byte sent. On an ACK (SDA low on the ninth clock) it sends the next byte.
- R8: After a NACK (SDA high on the ninth clock) the block drives nothing until a start or stop.
- R9: A repeated start keeps the pointer, so a read that follows a pointer-setting write begins at that location.
- R10: The pull-down enable only turns on while the filtered SCL is low.
- R11: A pulse of a single system-clock cycle on SCL is ignored and does not shift in an extra bit.
- R12: After reset the pull-down enable is off and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Board-strapped low three address bits |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |

## Verification
The assertions assume a well-behaved controller. It changes SDA only while SCL is low, except to form start and stop conditions. Its SCL phases last many system clocks, so the filter latency never reorders an SCL edge and an SDA change. The bench drives SDA a quarter period into each low phase and holds each SCL level for fifty clocks, which keeps every transition well inside those bounds. The single deliberate glitch is one clock wide and lies inside an SCL high phase, away from any SDA change.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam logic [3:0] TYPE_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK,
        ST_HOLD
    } bus_st_e;

endpackage

// File: rtl/i2c_rb_deglitch.sv
module i2c_rb_deglitch #(
    parameter int LINES = 2,
    parameter int SYNC  = 2,
    parameter int HIST  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] in_i,
    output logic [LINES-1:0] out_o
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [SYNC-1:0] sync_d, sync_q;
            logic [HIST-1:0] hist_d, hist_q;
            logic            out_d, out_q;

            always_comb begin
                sync_d = {sync_q[SYNC-2:0], in_i[g]};
                hist_d = {hist_q[HIST-2:0], sync_q[SYNC-1]};
                out_d  = out_q;
                // level only moves when every recent sample agrees
                if (&hist_q)       out_d = 1'b1;
                else if (~|hist_q) out_d = 1'b0;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '1;
                    hist_q <= '1;
                    out_q  <= 1'b1;
                end else begin
                    sync_q <= sync_d;
                    hist_q <= hist_d;
                    out_q  <= out_d;
                end
            end

            assign out_o[g] = out_q;
        end
    endgenerate

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R6: a write strobe lands its byte at the addressed slot
    p_wr_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
    import i2c_rb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic [6:0]    dev_addr,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sda_oe
);

    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    typedef struct packed {
        bus_st_e       st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [AW-1:0] ptr;
        logic          rw;
        logic          ptr_pend;
        logic          mack;
        logic          oe;
        logic          scl_p;
        logic          sda_p;
    } eng_t;

    eng_t r_q, r_d;
    logic scl_rise, scl_fall, start_det, stop_det;

    always_comb begin
        scl_rise  = !r_q.scl_p && scl_f;
        scl_fall  = r_q.scl_p && !scl_f;
        start_det = r_q.scl_p && scl_f && r_q.sda_p && !sda_f;
        stop_det  = r_q.scl_p && scl_f && !r_q.sda_p && sda_f;
    end

    always_comb begin
        r_d       = r_q;
        r_d.scl_p = scl_f;
        r_d.sda_p = sda_f;
        wr_en     = 1'b0;
        wr_addr   = r_q.ptr;
        wr_data   = r_q.sh;

        if (start_det) begin
            r_d.st  = ST_HDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else if (stop_det) begin
            r_d.st  = ST_IDLE;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_HDR: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[DW-2:0], sda_f};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST) begin
                        if (r_q.sh[7:1] == dev_addr) begin
                            r_d.st = ST_HACK;
                            r_d.oe = 1'b1;
                            r_d.rw = r_q.sh[0];
                        end else begin
                            r_d.st = ST_HOLD;
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.st = ST_RBYTE;
                            r_d.sh = rd_data;
                            r_d.oe = !rd_data[DW-1];
                        end else begin
                            r_d.st       = ST_WBYTE;
                            r_d.oe       = 1'b0;
                            r_d.ptr_pend = 1'b1;
                        end
                    end
                end
                ST_WBYTE: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[DW-2:0], sda_f};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall && r_q.cnt == LAST) begin
                        r_d.st = ST_WACK;
                        r_d.oe = 1'b1;
                        if (r_q.ptr_pend) begin
                            r_d.ptr      = r_q.sh[AW-1:0];
                            r_d.ptr_pend = 1'b0;
                        end else begin
                            wr_en   = 1'b1;
                            r_d.ptr = r_q.ptr + 1'b1;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        r_d.st  = ST_WBYTE;
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                    end
                end
                ST_RBYTE: begin
                    if (scl_rise) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.cnt == LAST) begin
                            r_d.st  = ST_RACK;
                            r_d.oe  = 1'b0;
                            r_d.ptr = r_q.ptr + 1'b1;
                        end else begin
                            r_d.sh = {r_q.sh[DW-2:0], 1'b0};
                            r_d.oe = !r_q.sh[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.mack = !sda_f;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.st  = ST_RBYTE;
                            r_d.cnt = '0;
                            r_d.sh  = rd_data;
                            r_d.oe  = !rd_data[DW-1];
                        end else begin
                            r_d.st = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.scl_p <= 1'b1;
            r_q.sda_p <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr = r_q.ptr;
    assign sda_oe  = r_q.oe;

    // R2: a stop leaves the line released and the engine idle
    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && r_q.st == ST_IDLE));

    // R4: the header acknowledge phase is only reached on a full address match
    p_addr_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HACK) |-> (r_q.sh[7:1] == {TYPE_CODE, dev_addr[2:0]}));

    // R10: the pull-down only switches on during the low half of SCL
    p_oe_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R3: the bit counter never runs past one byte
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST);

    // R8: after a refused byte, or a foreign header, nothing is driven
    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && $past(r_q.st) == ST_HOLD) |-> !sda_oe);

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o
);

    logic [1:0]    line_f;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_en;

    i2c_rb_deglitch #(.LINES(2), .SYNC(2), .HIST(3)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({scl_i, sda_i}),
        .out_o (line_f)
    );

    i2c_rb_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (line_f[1]),
        .sda_f    (line_f[0]),
        .dev_addr ({TYPE_CODE, strap_i}),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe_o)
    );

    i2c_rb_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;

    localparam int Q = 25;
    localparam logic [6:0] DEV = 7'b1010101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    logic       sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mem [256];
    logic [7:0] ptr = 8'h00;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_regbank_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one SCL period; the expected pull-down is compared on every clock of the high phase
    task automatic do_bit(input bit drv, input bit exp_oe, input string req,
                          input bit glitch, output bit seen);
        int bad = 0;
        logic bad_val = 1'b0;
        wait_clk(Q);
        sda_m = drv;
        wait_clk(Q);
        scl = 1'b1;
        seen = 1'b1;
        for (int i = 0; i < 2 * Q; i++) begin
            @(negedge clk);
            scl = !(glitch && i == 10);
            if (sda_oe !== exp_oe) begin
                bad++;
                bad_val = sda_oe;
            end
            if (i == Q) seen = sda_bus;
        end
        scl = 1'b0;
        chk(bad == 0, req, bad == 0 ? int'(exp_oe) : int'(bad_val), int'(exp_oe));
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req,
                             input bit glitch, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) do_bit(b[i], 1'b0, req, glitch && i == 3, s);
        do_bit(1'b1, exp_ack, req, 1'b0, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit m_ack, input bit drives,
                             input string req);
        bit s;
        logic [7:0] got = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            do_bit(1'b1, drives ? !exp[i] : 1'b0, req, 1'b0, s);
            got = {got[6:0], s};
        end
        do_bit(!m_ack, 1'b0, req, 1'b0, s);
        if (drives) chk(got == exp, req, got, exp);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        scl = 1'b1;
        wait_clk(2 * Q);
        sda_m = 1'b0;
        wait_clk(2 * Q);
        scl = 1'b0;
    endtask

    task automatic bus_rstart();
        wait_clk(Q);
        sda_m = 1'b1;
        wait_clk(Q);
        scl = 1'b1;
        wait_clk(Q);
        sda_m = 1'b0;
        wait_clk(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop(input string req);
        wait_clk(Q);
        sda_m = 1'b0;
        wait_clk(Q);
        scl = 1'b1;
        wait_clk(Q);
        sda_m = 1'b1;
        wait_clk(2 * Q);
        chk(sda_oe == 1'b0, req, sda_oe, 0);
    endtask

    task automatic write_regs(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1,
                              input logic [7:0] d2, input bit glitch, input string req);
        bit a;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R5", 1'b0, a);
        chk(a, "R5", a, 1);
        send_byte(p, 1'b1, "R6", 1'b0, a);
        ptr = p;
        for (int k = 0; k < 3; k++) begin
            send_byte(dv[k], 1'b1, req, glitch, a);
            chk(a, req, a, 1);
            mem[ptr] = dv[k];
            ptr = ptr + 8'd1;
        end
        bus_stop("R2");
    endtask

    task automatic read_from(input logic [7:0] p, input int n, input string req);
        bit a;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R5", 1'b0, a);
        send_byte(p, 1'b1, "R6", 1'b0, a);
        ptr = p;
        bus_rstart();
        send_byte({DEV, 1'b1}, 1'b1, "R9", 1'b0, a);
        chk(a, "R3", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(mem[ptr], k < n - 1, 1'b1, req);
            ptr = ptr + 8'd1;
        end
        bus_stop("R2");
    endtask

    initial begin
        bit a;
        bit s;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wait_clk(4);
        chk(sda_oe == 1'b0, "R12", sda_oe, 0);
        rst_n = 1'b1;
        wait_clk(10);
        chk(sda_oe == 1'b0, "R12", sda_oe, 0);

        // R12: untouched register reads zero
        read_from(8'h80, 1, "R12");

        // R6 R5: pointer load then burst write
        write_regs(8'h10, 8'hA5, 8'h3C, 8'hF0, 1'b0, "R6");
        // R7 R9: random read of the burst
        read_from(8'h10, 3, "R7");

        // R7: current-address read continues from the pointer
        bus_start();
        send_byte({DEV, 1'b1}, 1'b1, "R3", 1'b0, a);
        recv_byte(mem[ptr], 1'b0, 1'b1, "R7");
        ptr = ptr + 8'd1;
        bus_stop("R2");

        // R4: wrong type code, then wrong strap bits
        bus_start();
        send_byte({4'b1011, strap, 1'b0}, 1'b0, "R4", 1'b0, a);
        chk(!a, "R4", a, 0);
        send_byte(8'h10, 1'b0, "R4", 1'b0, a);
        send_byte(8'h99, 1'b0, "R4", 1'b0, a);
        bus_stop("R4");
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, 1'b0, "R4", 1'b0, a);
        chk(!a, "R4", a, 0);
        send_byte(8'h11, 1'b0, "R4", 1'b0, a);
        send_byte(8'h66, 1'b0, "R4", 1'b0, a);
        bus_stop("R4");
        read_from(8'h10, 2, "R4");

        // R6: pointer wraps from 255 to 0
        write_regs(8'hFE, 8'h11, 8'h22, 8'h33, 1'b0, "R6");
        read_from(8'hFE, 3, "R6");

        // R8: after a NACK nothing is driven
        read_from(8'h10, 1, "R8");
        bus_start();
        send_byte({DEV, 1'b1}, 1'b1, "R8", 1'b0, a);
        recv_byte(mem[ptr], 1'b0, 1'b1, "R8");
        ptr = ptr + 8'd1;
        recv_byte(8'h00, 1'b0, 1'b0, "R8");
        bus_stop("R8");

        // R1 R2: stop part way through a header, then a normal transfer
        bus_start();
        for (int i = 0; i < 4; i++) do_bit(DEV[6 - i], 1'b0, "R1", 1'b0, s);
        bus_stop("R2");

        // R11: one-clock SCL glitches inside data bytes
        write_regs(8'h40, 8'h5A, 8'hC3, 8'h81, 1'b1, "R11");
        read_from(8'h40, 3, "R11");

        // R1: repeated start from within a write data phase
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R1", 1'b0, a);
        send_byte(8'h12, 1'b1, "R1", 1'b0, a);
        ptr = 8'h12;
        bus_rstart();
        send_byte({DEV, 1'b1}, 1'b1, "R1", 1'b0, a);
        recv_byte(mem[ptr], 1'b0, 1'b1, "R9");
        ptr = ptr + 8'd1;
        bus_stop("R2");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule